// File: doc/BRIEF.md
# Converter Arm Sub-module Firing Selector

This block drives the insertion pattern of a pair of series-connected converter arms (upper and lower), each built from `N_SM` switched capacitor cells. Each cell is either inserted (its capacitor adds to the arm voltage) or shorted, so one firing bit per cell is enough. On an update strobe, a signed fixed-point reference sample is turned into a lower-arm insertion count. The upper-arm count is the remainder of the usable cell count.

Within each arm, the block ranks the healthy cells by their measured capacitor voltage. It inserts the lowest-voltage cells when the arm current charges inserted capacitors, and the highest-voltage cells when it discharges them. This keeps the capacitor voltages close together. Cells marked as bypassed take no part in the count or the ranking, and their firing bits are always off. The ranking is redone only when the insertion count or a bypass mask has changed since the last ranking. Otherwise the current firing pattern is kept.

Top module: `mmc_arm_fire_sel`

## Requirements
- R1: After reset, both firing vectors are all zero and `done_o` is low.
- R2: The reference `ref_i` is signed, with `2^(REF_W-2)` representing +1.0. Let M be the smaller of the healthy-cell counts of the two arms and v the clamped reference. The lower count is NL = floor((M·(v+1)/2)·... rounded half up), computed exactly as floor((M·(x) + 2^(REF_W-2)) / 2^(REF_W-1)) with x = v·2^(REF_W-2) + 2^(REF_W-2). The upper count is NU = M − NL. After each completed update, each arm has exactly its count of firing bits set.
- R3: Reference values above +1.0 or below −1.0 are saturated to ±1.0 before quantization.
- R4: With `cur_pos_*_i` = 1 (the current charges inserted capacitors), an arm inserts its healthy cells with the lowest voltages. Among equal voltages, the lower cell index is taken first.
- R5: With `cur_pos_*_i` = 0, an arm inserts its healthy cells with the highest voltages. Among equal voltages, the lower cell index is taken first.
- R6: The two arms are ranked and selected independently, each using its own voltages, current sign and bypass mask.
- R7: A cell whose bit is 1 in `byp_*_i` is never selected and is not counted in M. Its firing output is off from the cycle the mask bit is seen, even before any update.
- R8: An accepted strobe re-ranks only if the new NL differs from the NL of the previous accepted strobe, if either bypass mask differs from the previous accepted strobe, or if it is the first strobe after reset. Otherwise the firing vectors are held, even when voltages or current signs have changed, and `done_o` is high in the cycle after the accepting edge.
- R9: For a strobe that re-ranks, the firing vectors change together, and `done_o` is high in the cycle after the (N_SM+1)-th rising edge following the accepting edge. The firing vectors do not change at any other time.
- R10: A strobe that arrives while a ranking is in progress, or in the cycle in which `done_o` is high, is ignored. It produces no extra `done_o` and does not change the result.
- R11: `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Update strobe |
| ref_i | input | REF_W | Signed reference sample, +1.0 = 2^(REF_W-2) |
| vcap_up_i | input | N_SM*VCAP_W | Upper-arm capacitor voltages, cell i in bits [i*VCAP_W +: VCAP_W] |
| vcap_lo_i | input | N_SM*VCAP_W | Lower-arm capacitor voltages, same packing |
| cur_pos_up_i | input | 1 | Upper-arm current charges inserted cells |
| cur_pos_lo_i | input | 1 | Lower-arm current charges inserted cells |
| byp_up_i | input | N_SM | Upper-arm bypass mask, bit i = cell i |
| byp_lo_i | input | N_SM | Lower-arm bypass mask, bit i = cell i |
| fire_up_o | output | N_SM | Upper-arm firing bits, 1 = inserted |
| fire_lo_o | output | N_SM | Lower-arm firing bits, 1 = inserted |
| done_o | output | 1 | Pulse marking a firing update or a hold |

## Verification
A corrupted rank table or a wrong swap parity shows up as the wrong set of inserted cells at the very next `done_o`. If the quantizer or the usable count is wrong, the number of set firing bits differs from NU or NL in that same cycle. A state machine that mishandles the change test reveals itself through the `done_o` latency: one cycle for a hold and N_SM+2 sample points for a re-rank. Any stray firing change between pulses is visible at once on the outputs. The directed scenarios use distinct voltages, fully tied voltages, saturated references, rounding on both sides of one half, bypassed cells and strobes arriving while busy, so each of these faults produces a different pattern within one update.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SORT   = 2'd1,
      ST_COMMIT = 2'd2
   } fsel_state_e;

   localparam int unsigned ARM_COUNT = 2;
endpackage

// File: rtl/fsel_level_quant.sv
module fsel_level_quant #(
   parameter int N_SM  = 8,
   parameter int REF_W = 16
) (
   input  logic signed [REF_W-1:0]         ref_i,
   input  logic [N_SM-1:0]                 byp_up_i,
   input  logic [N_SM-1:0]                 byp_lo_i,
   output logic [$clog2(N_SM+1)-1:0]       m_o,
   output logic [$clog2(N_SM+1)-1:0]       nl_o,
   output logic [$clog2(N_SM+1)-1:0]       nu_o
);
   localparam int CW = $clog2(N_SM+1);
   localparam int PW = CW + REF_W;
   localparam logic signed [REF_W-1:0] P_ONE = REF_W'(1 << (REF_W-2));
   localparam logic signed [REF_W-1:0] N_ONE = -P_ONE;

   logic signed [REF_W-1:0] ref_c;
   logic [REF_W-1:0]        shifted;
   logic [CW-1:0]           h_up, h_lo;
   logic [PW-1:0]           prod;

   always_comb begin
      if (ref_i > P_ONE)      ref_c = P_ONE;
      else if (ref_i < N_ONE) ref_c = N_ONE;
      else                    ref_c = ref_i;
      shifted = REF_W'(ref_c + P_ONE);
   end

   always_comb begin
      h_up = CW'($countones(~byp_up_i));
      h_lo = CW'($countones(~byp_lo_i));
      m_o  = (h_up < h_lo) ? h_up : h_lo;
      prod = PW'(m_o) * PW'(shifted) + PW'(P_ONE);
      nl_o = CW'(prod >> (REF_W-1));
      nu_o = m_o - nl_o;
   end
endmodule

// File: rtl/fsel_rank_sorter.sv
module fsel_rank_sorter #(
   parameter int N_SM   = 8,
   parameter int VCAP_W = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load_i,
   input  logic                       step_i,
   input  logic                       odd_i,
   input  logic                       chk_i,
   input  logic                       cur_pos_i,
   input  logic [N_SM*VCAP_W-1:0]     vcap_i,
   input  logic [N_SM-1:0]            byp_i,
   input  logic [$clog2(N_SM+1)-1:0]  k_i,
   output logic [N_SM-1:0]            sel_o
);
   localparam int IW = $clog2(N_SM);
   localparam int CW = $clog2(N_SM+1);
   localparam int KW = 1 + VCAP_W + IW;

   // key = {bypassed, oriented voltage, index}: ascending order puts the
   // preferred healthy cells first, ties resolved by lower index
   logic [KW-1:0] key_q [N_SM];
   logic [KW-1:0] key_d [N_SM];
   logic [KW-1:0] key_ld [N_SM];

   for (genvar g = 0; g < N_SM; g++) begin : g_load
      logic [VCAP_W-1:0] v;
      assign v         = vcap_i[g*VCAP_W +: VCAP_W];
      assign key_ld[g] = {byp_i[g], (cur_pos_i ? v : ~v), IW'(g)};
   end

   always_comb begin
      key_d = key_q;
      for (int j = 0; j < N_SM-1; j++) begin
         if (((j % 2) == 1) == odd_i && key_q[j] > key_q[j+1]) begin
            key_d[j]   = key_q[j+1];
            key_d[j+1] = key_q[j];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_SM; i++) key_q[i] <= '0;
      end else if (load_i) begin
         key_q <= key_ld;
      end else if (step_i) begin
         key_q <= key_d;
      end
   end

   always_comb begin
      sel_o = '0;
      for (int r = 0; r < N_SM; r++) begin
         if (CW'(r) < k_i && !key_q[r][KW-1])
            sel_o[key_q[r][IW-1:0]] = 1'b1;
      end
   end

   for (genvar j = 0; j < N_SM-1; j++) begin : g_order_chk
      assert_rank_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
         chk_i |-> key_q[j] <= key_q[j+1]);
   end
endmodule

// File: rtl/mmc_arm_fire_sel.sv
module mmc_arm_fire_sel #(
   parameter int N_SM   = 8,
   parameter int VCAP_W = 12,
   parameter int REF_W  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     upd_i,
   input  logic signed [REF_W-1:0]  ref_i,
   input  logic [N_SM*VCAP_W-1:0]   vcap_up_i,
   input  logic [N_SM*VCAP_W-1:0]   vcap_lo_i,
   input  logic                     cur_pos_up_i,
   input  logic                     cur_pos_lo_i,
   input  logic [N_SM-1:0]          byp_up_i,
   input  logic [N_SM-1:0]          byp_lo_i,
   output logic [N_SM-1:0]          fire_up_o,
   output logic [N_SM-1:0]          fire_lo_o,
   output logic                     done_o
);
   import fsel_pkg::*;

   localparam int CW  = $clog2(N_SM+1);
   localparam int PCW = $clog2(N_SM);

   if (N_SM < 2)   begin : g_bad_n   $error("N_SM must be at least 2");   end
   if (VCAP_W < 2) begin : g_bad_vw  $error("VCAP_W must be at least 2"); end
   if (REF_W < 4)  begin : g_bad_rw  $error("REF_W must be at least 4");  end

   fsel_state_e       state_q;
   logic [PCW-1:0]    pass_q;
   logic [CW-1:0]     k_up_q, k_lo_q, nl_last_q;
   logic [N_SM-1:0]   byp_up_last_q, byp_lo_last_q;
   logic              valid_q, done_q;
   logic [N_SM-1:0]   fire_up_q, fire_lo_q;

   logic [CW-1:0]     m_w, nl_w, nu_w;
   logic              accept, change, load, step, chk;

   fsel_level_quant #(.N_SM(N_SM), .REF_W(REF_W)) quant_i (
      .ref_i    (ref_i),
      .byp_up_i (byp_up_i),
      .byp_lo_i (byp_lo_i),
      .m_o      (m_w),
      .nl_o     (nl_w),
      .nu_o     (nu_w)
   );

   assign accept = (state_q == ST_IDLE) && !done_q && upd_i;
   assign change = !valid_q || (nl_w != nl_last_q) ||
                   (byp_up_i != byp_up_last_q) || (byp_lo_i != byp_lo_last_q);
   assign load   = accept && change;
   assign step   = (state_q == ST_SORT);
   assign chk    = (state_q == ST_COMMIT);

   // arm 0 = upper, arm 1 = lower
   logic [N_SM*VCAP_W-1:0] vcap_a [ARM_COUNT];
   logic [N_SM-1:0]        byp_a  [ARM_COUNT];
   logic                   cpos_a [ARM_COUNT];
   logic [CW-1:0]          k_a    [ARM_COUNT];
   logic [N_SM-1:0]        sel_a  [ARM_COUNT];

   assign vcap_a[0] = vcap_up_i;
   assign vcap_a[1] = vcap_lo_i;
   assign byp_a[0]  = byp_up_i;
   assign byp_a[1]  = byp_lo_i;
   assign cpos_a[0] = cur_pos_up_i;
   assign cpos_a[1] = cur_pos_lo_i;
   assign k_a[0]    = k_up_q;
   assign k_a[1]    = k_lo_q;

   for (genvar a = 0; a < ARM_COUNT; a++) begin : g_arm
      fsel_rank_sorter #(.N_SM(N_SM), .VCAP_W(VCAP_W)) sorter_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_i    (load),
         .step_i    (step),
         .odd_i     (pass_q[0]),
         .chk_i     (chk),
         .cur_pos_i (cpos_a[a]),
         .vcap_i    (vcap_a[a]),
         .byp_i     (byp_a[a]),
         .k_i       (k_a[a]),
         .sel_o     (sel_a[a])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         pass_q        <= '0;
         k_up_q        <= '0;
         k_lo_q        <= '0;
         nl_last_q     <= '0;
         byp_up_last_q <= '0;
         byp_lo_last_q <= '0;
         valid_q       <= 1'b0;
         done_q        <= 1'b0;
         fire_up_q     <= '0;
         fire_lo_q     <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  nl_last_q     <= nl_w;
                  byp_up_last_q <= byp_up_i;
                  byp_lo_last_q <= byp_lo_i;
                  valid_q       <= 1'b1;
                  if (change) begin
                     k_up_q  <= nu_w;
                     k_lo_q  <= nl_w;
                     pass_q  <= '0;
                     state_q <= ST_SORT;
                  end else begin
                     done_q <= 1'b1;
                  end
               end
            end
            ST_SORT: begin
               pass_q <= pass_q + PCW'(1);
               if (pass_q == PCW'(N_SM-1)) state_q <= ST_COMMIT;
            end
            ST_COMMIT: begin
               fire_up_q <= sel_a[0];
               fire_lo_q <= sel_a[1];
               done_q    <= 1'b1;
               state_q   <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign fire_up_o = fire_up_q & ~byp_up_i;
   assign fire_lo_o = fire_lo_q & ~byp_lo_i;
   assign done_o    = done_q;

   assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      nl_w <= m_w);
   assert_fire_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ($countones(fire_up_q) == int'(k_up_q)) &&
                 ($countones(fire_lo_q) == int'(k_lo_q)));
   assert_byp_excluded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ((fire_up_q & byp_up_last_q) == '0) &&
                 ((fire_lo_q & byp_lo_last_q) == '0));
   assert_fire_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> $stable(fire_up_q) && $stable(fire_lo_q));
   assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(nl_last_q) && $stable(byp_up_last_q));
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
endmodule

// File: tb/mmc_arm_fire_sel_tb_top.sv
`timescale 1ns/1ps
module mmc_arm_fire_sel_tb_top;
   localparam int N  = 8;
   localparam int VW = 12;
   localparam int RW = 16;
   localparam int ONE = 1 << (RW-2);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic upd = 1'b0;
   logic signed [RW-1:0] ref_drv = '0;
   logic [VW-1:0] vu [N];
   logic [VW-1:0] vl [N];
   logic cpu = 1'b1, cpl = 1'b1;
   logic [N-1:0] bu = '0, bl = '0;
   logic [N*VW-1:0] vu_p, vl_p;
   logic [N-1:0] fire_up, fire_lo;
   logic done;

   int checks = 0, errors = 0;
   bit finished = 0;
   logic [N-1:0] int_up = '0, int_lo = '0;

   always #2 clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         vu_p[i*VW +: VW] = vu[i];
         vl_p[i*VW +: VW] = vl[i];
      end
   end

   mmc_arm_fire_sel #(.N_SM(N), .VCAP_W(VW), .REF_W(RW)) dut_i (
      .clk(clk), .rst_n(rst_n), .upd_i(upd), .ref_i(ref_drv),
      .vcap_up_i(vu_p), .vcap_lo_i(vl_p),
      .cur_pos_up_i(cpu), .cur_pos_lo_i(cpl),
      .byp_up_i(bu), .byp_lo_i(bl),
      .fire_up_o(fire_up), .fire_lo_o(fire_lo), .done_o(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [N-1:0] pick(input logic [VW-1:0] v [N],
                                          input logic [N-1:0] b, input logic pos,
                                          input int k);
      logic [N-1:0] s;
      s = '0;
      for (int n = 0; n < k; n++) begin
         int best;
         best = -1;
         for (int i = 0; i < N; i++)
            if (!b[i] && !s[i])
               if (best < 0 || (pos ? (v[i] < v[best]) : (v[i] > v[best])))
                  best = i;
         if (best >= 0) s[best] = 1'b1;
      end
      return s;
   endfunction

   function automatic int exp_nl(input int m, input int r);
      int rc;
      rc = (r > ONE) ? ONE : ((r < -ONE) ? -ONE : r);
      return (m * (rc + ONE) + ONE) / (2 * ONE);
   endfunction

   // one strobe, waits for done, checks latency, pattern and pulse shape
   task automatic run_update(input logic signed [RW-1:0] r, input bit resort,
                             input bit poke, input string req);
      int m, nl, nu, cnt;
      logic [N-1:0] exp_up, exp_lo, before_up, before_lo;
      bit early;
      m  = $countones(~bu) < $countones(~bl) ? $countones(~bu) : $countones(~bl);
      nl = exp_nl(m, int'(r));
      nu = m - nl;
      exp_up = resort ? pick(vu, bu, cpu, nu) : int_up;
      exp_lo = resort ? pick(vl, bl, cpl, nl) : int_lo;
      @(negedge clk);
      before_up = fire_up; before_lo = fire_lo;
      ref_drv = r; upd = 1'b1;
      @(posedge clk);
      cnt = 0; early = 0;
      while (cnt < 100) begin
         @(negedge clk);
         cnt++;
         upd = (poke && cnt == 3);
         if (poke && cnt == 3) ref_drv = -r - 16'sd3000;
         if (done) break;
         if (fire_up != before_up || fire_lo != before_lo) early = 1;
      end
      upd = 1'b0;
      chk(cnt == (resort ? N + 2 : 1), resort ? "R9" : "R8", "done latency",
          cnt, resort ? N + 2 : 1);
      chk(!early, "R9", "firing changed before done", int'(early), 0);
      chk(fire_up == (exp_up & ~bu), req, "upper firing", fire_up, exp_up & ~bu);
      chk(fire_lo == (exp_lo & ~bl), req, "lower firing", fire_lo, exp_lo & ~bl);
      chk($countones(fire_up) == nu && $countones(fire_lo) == nl, "R2",
          "insert counts", $countones(fire_up) * 16 + $countones(fire_lo), nu * 16 + nl);
      int_up = exp_up; int_lo = exp_lo;
      @(negedge clk);
      chk(!done, "R11", "done width", int'(done), 0);
      if (poke) begin
         ref_drv = r;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!done, "R10", "extra done after busy strobe", int'(done), 0);
         end
      end
   endtask

   task automatic set_volts(input int su, input int sl);
      for (int i = 0; i < N; i++) begin
         vu[i] = VW'(((i * su + 11) % 29) * 97 + 400);
         vl[i] = VW'(((i * sl + 5) % 31) * 83 + 300);
      end
   endtask

   task automatic t_reset;
      chk(fire_up == '0 && fire_lo == '0, "R1", "firing after reset",
          {fire_up, fire_lo}, 0);
      chk(!done, "R1", "done after reset", int'(done), 0);
   endtask

   task automatic t_mid_level;  // NL = 4, NU = 4, arms with opposite currents
      set_volts(7, 13);
      cpu = 1'b0; cpl = 1'b1;
      run_update(16'sd0, 1, 0, "R6");
   endtask

   task automatic t_full_positive;  // NL = 8, NU = 0
      set_volts(5, 3);
      cpu = 1'b1; cpl = 1'b0;
      run_update(16'sd16384, 1, 0, "R5");
   endtask

   task automatic t_saturate;  // clamps to +1 -> same NL, hold; then -1 -> NL 0
      set_volts(11, 17);
      cpu = 1'b0; cpl = 1'b1;
      run_update(16'sh7fff, 0, 0, "R3");
      run_update(-16'sd32768, 1, 0, "R3");
   endtask

   task automatic t_ties;  // equal voltages: lowest indices in both directions
      for (int i = 0; i < N; i++) begin vu[i] = 12'd2000; vl[i] = 12'd2000; end
      cpu = 1'b0; cpl = 1'b1;
      run_update(-16'sd6144, 1, 0, "R4");   // exactly 2.5 -> rounds up to 3
      chk(fire_lo == 8'h07 && fire_up == 8'h1f, "R5", "tie order",
          {fire_up, fire_lo}, 16'h1f07);
      set_volts(3, 9);
      run_update(-16'sd6145, 1, 0, "R4");   // just under 2.5 -> 2
   endtask

   task automatic t_bypass;
      bu = int_up | 8'h01;
      bl = 8'h40;
      @(negedge clk);
      chk(fire_up == (int_up & ~bu), "R7", "bypassed bit forced off",
          fire_up, int_up & ~bu);
      set_volts(13, 2);
      cpu = 1'b1; cpl = 1'b0;
      run_update(16'sd0, 1, 0, "R7");
   endtask

   task automatic t_busy_strobe;
      bu = '0; bl = '0;
      set_volts(19, 23);
      run_update(16'sd5000, 1, 1, "R10");
   endtask

   task automatic t_sign_only;  // same NL and masks, new currents and volts: hold
      cpu = ~cpu; cpl = ~cpl;
      set_volts(2, 27);
      run_update(16'sd5000, 0, 0, "R8");
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin vu[i] = '0; vl[i] = '0; end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_mid_level();
      t_full_positive();
      t_saturate();
      t_ties();
      t_bypass();
      t_busy_strobe();
      t_sign_only();
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors + 0);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule